// File: doc/BRIEF.md
# Framed SPI Bus Master

This block is a synchronous serial bus master. It derives the serial clock from the system clock through a half-period divider and supports all four clock polarity and phase modes. It drives one active-low select line per attached slave. A one-cycle start request launches a full-duplex frame. Every serial clock cycle sends one bit out on MOSI and takes one bit in from MISO, most significant bit first, with words of 8 or 16 bits.

A frame holds one or more back-to-back words under a single select assertion. Between words the serial clock rests at its idle level and the select stays low. This lets a string of daisy-chained slaves be written or read in one burst: sending N words leaves the first word in the slave farthest from the master. Reading the string back takes N filler words. Each received word is presented on a parallel output together with a one-cycle valid strobe. The word to transmit is sampled from a parallel input at the start of each word.

Top module: `spi_chain_master`

## Requirements
- R1: While reset is held, every select is high, busy and rx_valid are low, and sclk equals the cpol input.
- R2: At most one select is ever low. During a frame, the low select is ss_n[target], where target is captured at the start request. All selects are high once busy drops.
- R3: When no frame runs, sclk equals cpol (0: low, 1: high). A frame produces exactly 2×W sclk transitions per word (W = 8 or 16), and sclk is back at its idle level when the select is released.
- R4: Bits leave on MOSI and arrive on MISO most significant bit first. With cpha=0, the first bit is on MOSI before the first edge, MISO is sampled on each leading edge, and MOSI changes on trailing edges. With cpha=1, MOSI changes on leading edges and MISO is sampled on trailing edges.
- R5: word16=1 selects 16-bit words. word16=0 selects 8-bit words: only tx_data[7:0] is sent, and rx_data[15:8] reads zero.
- R6: A half period lasts 2^div_sel system clocks. At least one half period separates the select fall from the first sclk edge. At least one half period separates the last sclk edge from the select rise.
- R7: A frame carries burst_len+1 words under one continuous select assertion. tx_data is sampled at the start of each word: one cycle after start for the first word, and after the previous word's rx_valid for later words.
- R8: busy rises on the cycle after an accepted start and stays high until the select is released. rx_valid is a single-cycle pulse after each word's last edge, with rx_data holding that word.
- R9: A start request raised while busy is ignored. The running frame keeps its select and word count, and no extra frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle frame request, accepted when idle |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| word16 | input | 1 | 1: 16-bit words; 0: 8-bit words |
| div_sel | input | DIV_W | Half period of 2^div_sel system clocks |
| target | input | SEL_W | Index of the slave select to drive |
| burst_len | input | LEN_W | Words in the frame minus one |
| tx_data | input | LONG_W | Word to transmit, sampled at each word start |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to slaves |
| miso | input | 1 | Serial data from slaves |
| ss_n | output | SEL_N | Active-low slave selects |
| busy | output | 1 | Frame in progress |
| rx_valid | output | 1 | One-cycle strobe per received word |
| rx_data | output | LONG_W | Last received word |

## Verification
The bench places a three-deep daisy-chained slave model behind the selects, so each received word is a bit-exact function of the chain contents and the words sent earlier. All four modes are run with single words, with short bursts and with a full eight-word burst. A mode whose sample or shift edge is misplaced shifts the received stream by one bit. 8-bit and 16-bit frames are mixed, with tx_data carrying nonzero upper bits in 8-bit mode, to show that the width selection truncates correctly. A write burst followed by a filler burst tells apart a correct chain push order from a reversed one. A start raised mid-frame with a different target and length shows whether the latched frame parameters are protected.

// File: rtl/spi_chain_pkg.sv
package spi_chain_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_LEAD,
        ST_SHIFT,
        ST_TRAIL
    } fsm_e;

endpackage

// File: rtl/spi_halfper_timer.sv
module spi_halfper_timer #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] div_sel,
    output logic             tick
);
    localparam int CNT_W = (1 << DIV_W) - 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W:0]   span;
    logic [CNT_W-1:0] limit;

    always_comb begin
        span  = (CNT_W + 1)'(1) << div_sel;
        limit = CNT_W'(span - (CNT_W + 1)'(1));
        tick  = !restart && (cnt_q == limit);
        if (restart || cnt_q == limit) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R6: with a half period above one clock, ticks are never back to back
    p_half_period_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div_sel != '0) |=> (!tick || div_sel != $past(div_sel)));

endmodule

// File: rtl/spi_word_shifter.sv
module spi_word_shifter #(
    parameter int LONG_W  = 16,
    parameter int SHORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              word16,
    input  logic              cpha,
    input  logic [LONG_W-1:0] tx_word,
    input  logic              edge_ev,
    input  logic              leading,
    input  logic              last_edge,
    input  logic              miso,
    output logic              mosi,
    output logic [LONG_W-1:0] rx_word,
    output logic              rx_valid
);
    localparam int PAD_W = LONG_W - SHORT_W;

    typedef struct packed {
        logic [LONG_W-1:0] tx_sh;
        logic [LONG_W-1:0] rx_sh;
        logic              mosi;
        logic              done;
    } shf_t;

    shf_t d, q;
    logic [LONG_W-1:0] aligned;
    logic              sample_now;
    logic              shift_now;

    always_comb begin
        d          = q;
        d.done     = 1'b0;
        aligned    = word16 ? tx_word : {tx_word[SHORT_W-1:0], {PAD_W{1'b0}}};
        sample_now = cpha ? !leading : leading;
        shift_now  = cpha ? leading : (!leading && !last_edge);
        if (load) begin
            d.rx_sh = '0;
            if (!cpha) begin
                d.mosi  = aligned[LONG_W-1];
                d.tx_sh = aligned << 1;
            end else begin
                d.mosi  = 1'b0;
                d.tx_sh = aligned;
            end
        end else if (edge_ev) begin
            if (sample_now) begin
                d.rx_sh = {q.rx_sh[LONG_W-2:0], miso};
            end
            if (shift_now) begin
                d.mosi  = q.tx_sh[LONG_W-1];
                d.tx_sh = q.tx_sh << 1;
            end
            d.done = last_edge;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign mosi     = q.mosi;
    assign rx_valid = q.done;
    assign rx_word  = word16 ? q.rx_sh : {{PAD_W{1'b0}}, q.rx_sh[SHORT_W-1:0]};

endmodule

// File: rtl/spi_chain_master.sv
module spi_chain_master
    import spi_chain_pkg::*;
#(
    parameter int SEL_N   = 4,
    parameter int LEN_W   = 3,
    parameter int DIV_W   = 3,
    parameter int LONG_W  = 16,
    parameter int SHORT_W = 8,
    localparam int SEL_W  = (SEL_N > 1) ? $clog2(SEL_N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              word16,
    input  logic [DIV_W-1:0]  div_sel,
    input  logic [SEL_W-1:0]  target,
    input  logic [LEN_W-1:0]  burst_len,
    input  logic [LONG_W-1:0] tx_data,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [SEL_N-1:0]  ss_n,
    output logic              busy,
    output logic              rx_valid,
    output logic [LONG_W-1:0] rx_data
);
    localparam int EDGE_W = $clog2(2 * LONG_W);
    localparam logic [EDGE_W-1:0] LAST_LONG  = EDGE_W'(2 * LONG_W - 1);
    localparam logic [EDGE_W-1:0] LAST_SHORT = EDGE_W'(2 * SHORT_W - 1);

    typedef struct packed {
        fsm_e              st;
        logic              cpol;
        logic              cpha;
        logic              w16;
        logic [DIV_W-1:0]  div;
        logic [SEL_W-1:0]  target;
        logic [LEN_W-1:0]  left;
        logic [EDGE_W-1:0] ecnt;
        logic              sclk;
    } ctl_t;

    ctl_t d, q;

    logic              tick;
    logic              restart;
    logic              edge_ev;
    logic              leading;
    logic              last_edge;
    logic              load;
    logic [EDGE_W-1:0] edge_idx;

    assign restart  = (q.st == ST_IDLE) || (q.st == ST_LOAD);
    assign edge_idx = (q.st == ST_LEAD) ? '0 : q.ecnt;
    assign edge_ev  = tick && ((q.st == ST_LEAD) || (q.st == ST_SHIFT));
    assign leading  = !edge_idx[0];
    assign last_edge = (edge_idx == (q.w16 ? LAST_LONG : LAST_SHORT));
    assign load     = (q.st == ST_LOAD);

    spi_halfper_timer #(.DIV_W(DIV_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .div_sel (q.div),
        .tick    (tick)
    );

    spi_word_shifter #(.LONG_W(LONG_W), .SHORT_W(SHORT_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .word16    (q.w16),
        .cpha      (q.cpha),
        .tx_word   (tx_data),
        .edge_ev   (edge_ev),
        .leading   (leading),
        .last_edge (last_edge),
        .miso      (miso),
        .mosi      (mosi),
        .rx_word   (rx_data),
        .rx_valid  (rx_valid)
    );

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                d.sclk = cpol;
                if (start) begin
                    d.st     = ST_LOAD;
                    d.cpol   = cpol;
                    d.cpha   = cpha;
                    d.w16    = word16;
                    d.div    = div_sel;
                    d.target = target;
                    d.left   = burst_len;
                    d.ecnt   = '0;
                end
            end
            ST_LOAD: begin
                d.st   = ST_LEAD;
                d.ecnt = '0;
            end
            ST_LEAD: begin
                if (tick) begin
                    d.sclk = !q.sclk;
                    d.ecnt = EDGE_W'(1);
                    d.st   = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (tick) begin
                    d.sclk = !q.sclk;
                    d.ecnt = q.ecnt + EDGE_W'(1);
                    if (last_edge) begin
                        d.st = ST_TRAIL;
                    end
                end
            end
            ST_TRAIL: begin
                if (tick) begin
                    if (q.left == '0) begin
                        d.st = ST_IDLE;
                    end else begin
                        d.left = q.left - LEN_W'(1);
                        d.st   = ST_LOAD;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign busy = (q.st != ST_IDLE);
    assign sclk = busy ? q.sclk : cpol;

    for (genvar gi = 0; gi < SEL_N; gi++) begin : g_sel
        assign ss_n[gi] = !(busy && (q.target == SEL_W'(gi)));
    end

    // R2: never more than one slave selected
    p_one_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~ss_n));

    // R8: an accepted start makes the block busy on the next cycle
    p_start_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R8: the receive strobe lasts one cycle
    p_rx_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R3: the clock rests at its idle level when the select is released
    p_idle_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(&ss_n) |-> ($past(sclk) == $past(q.cpol)));

endmodule

// File: tb/sim_spi_chain_master.sv
module sim_spi_chain_master;
    localparam int SEL_N = 4, LEN_W = 3, DIV_W = 3, LONG_W = 16, SHORT_W = 8;

    logic              clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic              cpol = 1'b0, cpha = 1'b0, word16 = 1'b0;
    logic [DIV_W-1:0]  div_sel = '0;
    logic [1:0]        target = '0;
    logic [LEN_W-1:0]  burst_len = '0;
    logic [15:0]       tx_data = '0;
    logic              sclk, mosi, miso, busy, rx_valid;
    logic [3:0]        ss_n;
    logic [15:0]       rx_data;

    always #5 clk = ~clk;

    spi_chain_master u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .cpol(cpol), .cpha(cpha),
        .word16(word16), .div_sel(div_sel), .target(target), .burst_len(burst_len),
        .tx_data(tx_data), .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n),
        .busy(busy), .rx_valid(rx_valid), .rx_data(rx_data)
    );

    int checks = 0, errors = 0;

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [47:0] lmask(int n);
        return (48'd1 << n) - 48'd1;
    endfunction

    // three-slave daisy chain behind whichever select the test picks
    logic [47:0] chain = '0;
    logic        cap = 1'b0, miso_b = 1'b0, m_cpol = 1'b0, m_cpha = 1'b0;
    int          chain_len = 24, model_sel = 0, frame_edges = 0;

    assign miso = m_cpha ? miso_b : chain[chain_len-1];

    always @(sclk) begin
        if (ss_n != 4'hF) frame_edges++;
        if (!ss_n[model_sel]) begin
            if (!m_cpha) begin
                if (sclk != m_cpol) cap = mosi;
                else chain = ((chain << 1) | {47'd0, cap}) & lmask(chain_len);
            end else begin
                if (sclk != m_cpol) miso_b = chain[chain_len-1];
                else chain = ((chain << 1) | {47'd0, mosi}) & lmask(chain_len);
            end
        end
    end

    // scoreboard and timing monitor
    logic [15:0] exp_q[$];
    logic [47:0] exp_chain = '0;
    int          exp_sel = 0, cyc = 0, t_sel = 0, t_edge = 0;
    int          lead_gap = 0, trail_gap = 0, sel_falls = 0;
    bit          prev_act = 1'b0, first_edge = 1'b0, act;
    logic        prev_sclk = 1'b0;
    logic [15:0] e;

    always @(negedge clk) begin
        cyc++;
        act = (ss_n != 4'hF);
        if (act && !prev_act) begin
            t_sel = cyc; first_edge = 1'b1; sel_falls++;
        end
        if (act && prev_act && sclk !== prev_sclk) begin
            if (first_edge) begin lead_gap = cyc - t_sel; first_edge = 1'b0; end
            t_edge = cyc;
        end
        if (!act && prev_act) trail_gap = cyc - t_edge;
        prev_act = act; prev_sclk = sclk;
        if (rx_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R8", "unexpected rx_valid", rx_data, 0);
            end else begin
                e = exp_q.pop_front();
                check(rx_data == e, "R4", "received word", rx_data, e);
                check(ss_n == ~(4'b0001 << exp_sel), "R2", "select during word",
                      ss_n, ~(4'b0001 << exp_sel));
            end
        end
        if (cyc > 150000) begin
            check(1'b0, "R8", "watchdog expired", cyc, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    logic [15:0] txw[8];

    task automatic set_chain(logic [47:0] v, bit w16);
        chain_len = w16 ? 48 : 24;
        chain     = v & lmask(chain_len);
        exp_chain = chain;
    endtask

    task automatic run_frame(int sel, bit pol, bit pha, bit w16, int dv, int n, bit poke);
        int W = w16 ? 16 : 8;
        int L = w16 ? 48 : 24;
        int half = 1 << dv;
        int falls0;
        logic [15:0] wm = w16 ? 16'hFFFF : 16'h00FF;
        logic [47:0] sh;
        @(negedge clk);
        cpol = pol; cpha = pha; word16 = w16; div_sel = DIV_W'(dv);
        target = 2'(sel); burst_len = LEN_W'(n - 1);
        m_cpol = pol; m_cpha = pha; model_sel = sel; exp_sel = sel;
        for (int k = 0; k < n; k++) begin
            sh = exp_chain >> (L - W);
            exp_q.push_back(sh[15:0] & wm);
            exp_chain = ((exp_chain << W) | {32'd0, txw[k] & wm}) & lmask(L);
        end
        @(negedge clk);
        frame_edges = 0; falls0 = sel_falls;
        tx_data = txw[0]; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R8", "busy after start", busy, 1);
        if (poke) begin
            repeat (3) @(negedge clk);
            target = 2'((sel + 1) % 4); burst_len = LEN_W'(n); start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        for (int k = 1; k < n; k++) begin
            do @(negedge clk); while (!rx_valid);
            tx_data = txw[k];
        end
        while (busy) @(negedge clk);
        @(negedge clk);
        check(exp_q.size() == 0, "R7", "words left unreceived", exp_q.size(), 0);
        check(frame_edges == 2 * W * n, "R3", "sclk transitions", frame_edges, 2 * W * n);
        check(sel_falls - falls0 == 1, "R7", "select assertions per frame", sel_falls - falls0, 1);
        check(lead_gap >= half, "R6", "select-to-first-edge gap", lead_gap, half);
        check(trail_gap >= half, "R6", "last-edge-to-release gap", trail_gap, half);
        check(sclk == pol, "R3", "idle sclk after frame", sclk, pol);
        check(ss_n == 4'hF, "R2", "selects released", ss_n, 4'hF);
        if (poke) begin
            repeat (2 * half + 10) @(negedge clk);
            check(!busy && sel_falls == falls0 + 1, "R9", "start while busy ignored",
                  sel_falls - falls0, 1);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(ss_n == 4'hF, "R1", "selects in reset", ss_n, 4'hF);
        check(busy == 1'b0, "R1", "busy in reset", busy, 0);
        check(rx_valid == 1'b0, "R1", "rx_valid in reset", rx_valid, 0);
        check(sclk == cpol, "R1", "sclk in reset", sclk, cpol);
        rst_n = 1'b1;
        @(negedge clk);
        cpol = 1'b1;
        #1 check(sclk == 1'b1, "R3", "idle sclk follows cpol", sclk, 1);

        // single words in each mode
        set_chain(48'h00_00_00_00_3C_5A, 1'b0);
        txw[0] = 16'h00A7;
        run_frame(0, 1'b0, 1'b0, 1'b0, 0, 1, 1'b0);
        txw[0] = 16'h0059;
        run_frame(1, 1'b0, 1'b1, 1'b0, 1, 1, 1'b0);
        txw[0] = 16'h00C3; txw[1] = 16'h0018;
        run_frame(2, 1'b1, 1'b0, 1'b0, 2, 2, 1'b0);

        // 16-bit word, mode 3
        set_chain(48'h9D2E_71B4_0F63, 1'b1);
        txw[0] = 16'hE41B;
        run_frame(3, 1'b1, 1'b1, 1'b1, 1, 1, 1'b0);

        // R5: upper byte ignored in 8-bit mode
        set_chain(48'h0000_0081_7EF0, 1'b0);
        txw[0] = 16'hA55A;
        run_frame(0, 1'b0, 1'b1, 1'b0, 0, 1, 1'b0);
        check(chain[7:0] == 8'h5A, "R5", "slave got low byte only", chain[7:0], 8'h5A);

        // R7: daisy chain write then filler readback
        set_chain(48'h0000_00D4_29E6, 1'b0);
        txw[0] = 16'h00A1; txw[1] = 16'h00B2; txw[2] = 16'h00C3;
        run_frame(1, 1'b0, 1'b0, 1'b0, 0, 3, 1'b0);
        check(chain[23:0] == 24'hA1B2C3, "R7", "chain order after burst", chain[23:0], 24'hA1B2C3);
        txw[0] = 16'h0000; txw[1] = 16'h0000; txw[2] = 16'h0000;
        run_frame(1, 1'b0, 1'b0, 1'b0, 0, 3, 1'b0);

        // R9: mid-frame start, 16-bit burst in mode 1
        set_chain(48'h1357_9BDF_2468, 1'b1);
        txw[0] = 16'hF00D; txw[1] = 16'h0BAD; txw[2] = 16'h7E57;
        run_frame(2, 1'b0, 1'b1, 1'b1, 0, 3, 1'b1);

        // longest burst, mode 3, 8-bit
        set_chain(48'h0000_0065_C38A, 1'b0);
        for (int k = 0; k < 8; k++) txw[k] = 16'(8'h11 * (k + 1));
        run_frame(3, 1'b1, 1'b1, 1'b0, 0, 8, 1'b0);
        check(chain[23:0] == 24'h667788, "R7", "chain tail after long burst", chain[23:0], 24'h667788);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule